// File: doc/BRIEF.md
# Prescaled 16-bit timer counter

This block is one timer channel: a 16-bit up-counter advanced by a programmable prescaler. A 4-bit code picks a power-of-two division of the system clock, or it picks edges of an external clock input. Two compare registers set the behaviour of each period. Compare B is the last count before the counter wraps to zero. Compare A is the point where the PWM output drops low. The output goes back high at each wrap. So the PWM output is high for counts 0 to A and low for counts A+1 to B.

Software reaches the channel through a small register port. The port has a write strobe, a 2-bit address, write data and a combinational read bus. Address 0 is control and status, address 1 is compare A, address 2 is compare B and address 3 reads the live count. The control word holds the following fields:

- bits [3:0]: clock code
- bit 4: run
- bit 5: one-shot mode
- bit 6: compare buffering
- bit 7: counter clear, write-only
- bit 8: busy, read-only

The counter can run in repeat mode or in one-shot mode. The compare values can be double-buffered so that a new value only takes effect at a period boundary. After each accepted control write, the channel stays busy for a short time and refuses further control writes until that time ends.

Top module: `ptimer`

## Requirements
- R1: After reset the control word reads 0x0000 (code 0, stopped, repeat, unbuffered, idle). Both compare registers read 0xFFFF, the count reads 0 and pwm_out is 1.
- R2: With clock code N in 0..14, the counter advances once every 2^N system clocks while running. Successive wraps are therefore (B+1)*2^N cycles apart.
- R3: With clock code 15, the counter advances once per rising edge of ext_clk, seen through a two-stage synchronizer. A static ext_clk never advances it.
- R4: While the run bit (bit 4) is 0, the count holds its value.
- R5: On a prescaled tick with the count equal to compare B, the count returns to 0 and cmpb_pulse is 1 for one cycle. In that same cycle pwm_out is 1.
- R6: On a prescaled tick with the count equal to compare A, cmpa_pulse is 1 for one cycle and pwm_out goes to 0. This puts cmpa_pulse (A+1) ticks after the preceding wrap.
- R7: With bit 5 set, the run bit clears itself at the first wrap. After that, no more pulses occur, the count stays 0, and the control word reads back with bit 4 at 0.
- R8: Writing a control word with bit 7 set returns the count to 0 on the next cycle. Bit 7 always reads back as 0.
- R9: With bit 6 set, compare writes land in shadow registers and reach the active compares only at a wrap. With bit 6 clear, they take effect at once.
- R10: An accepted control write makes bit 8 read 1 for exactly two cycles. A control write made while bit 8 is 1 is ignored.
- R11: Control bits 15:9 read as 0 whatever was written to them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ext_clk | input | 1 | External count clock, asynchronous |
| wr_en | input | 1 | Write strobe for the register port |
| addr | input | 2 | Register select for both read and write |
| wr_data | input | CNT_W | Write data |
| rd_data | output | CNT_W | Combinational read data for addr |
| cmpa_pulse | output | 1 | One-cycle compare-A match pulse |
| cmpb_pulse | output | 1 | One-cycle wrap pulse at compare B |
| pwm_out | output | 1 | PWM output |

## Verification
The bench builds the block with its defaults: a 16-bit counter, a 14-bit prescaler and a two-cycle busy window. With these defaults the whole divider range is reachable. Small compare values (B = 1 or 3) keep even the divide-by-16384 setting down to about 65,000 cycles, so the slowest code is measured, not just the fastest. Small compares also let the bench time a buffered compare change against the period already in progress. A slow external clock with a period of 12 system cycles exercises the synchronized edge path with exact wrap spacing.

// File: rtl/ptimer.sv
module ptimer #(
  parameter int CNT_W    = 16,
  parameter int PRE_W    = 14,
  parameter int BUSY_CYC = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ext_clk,
  input  logic             wr_en,
  input  logic [1:0]       addr,
  input  logic [CNT_W-1:0] wr_data,
  output logic [CNT_W-1:0] rd_data,
  output logic             cmpa_pulse,
  output logic             cmpb_pulse,
  output logic             pwm_out
);

  localparam int BW = $clog2(BUSY_CYC + 1);
  localparam logic [3:0] EXT_SEL = 4'hF;
  localparam logic [1:0] A_CTL = 2'd0, A_CMPA = 2'd1, A_CMPB = 2'd2, A_CNT = 2'd3;
  localparam int B_RUN = 4, B_ONE = 5, B_BUF = 6, B_CLR = 7, B_BUSY = 8;

  logic [3:0]       clk_sel;
  logic             run, one_shot, buf_en;
  logic [BW-1:0]    busy_cnt;
  logic [PRE_W-1:0] presc;
  logic [2:0]       ext_q;
  logic [CNT_W-1:0] cnt, cmpa, cmpb, sha, shb;

  wire busy     = busy_cnt != '0;
  wire ctl_wr   = wr_en && addr == A_CTL && !busy;
  wire clr      = ctl_wr && wr_data[B_CLR];
  wire wr_a     = wr_en && addr == A_CMPA;
  wire wr_b     = wr_en && addr == A_CMPB;
  wire ext_rise = ext_q[1] && !ext_q[2];

  wire [PRE_W-1:0] mask = ~({PRE_W{1'b1}} << clk_sel);
  wire tick  = run && ((clk_sel == EXT_SEL) ? ext_rise : ((presc & mask) == mask));
  wire wrap  = tick && cnt == cmpb;
  wire hit_a = tick && cnt == cmpa;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) ext_q <= '0;
    else        ext_q <= {ext_q[1:0], ext_clk};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)              presc <= '0;
    else if (!run || clr)    presc <= '0;
    else                     presc <= presc + PRE_W'(1);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      clk_sel  <= '0;
      run      <= 1'b0;
      one_shot <= 1'b0;
      buf_en   <= 1'b0;
    end else if (ctl_wr) begin
      clk_sel  <= wr_data[3:0];
      run      <= wr_data[B_RUN];
      one_shot <= wr_data[B_ONE];
      buf_en   <= wr_data[B_BUF];
    end else if (wrap && one_shot) begin
      run      <= 1'b0;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)      busy_cnt <= '0;
    else if (ctl_wr) busy_cnt <= BW'(BUSY_CYC);
    else if (busy)   busy_cnt <= busy_cnt - BW'(1);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)             cnt <= '0;
    else if (clr || wrap)   cnt <= '0;
    else if (tick)          cnt <= cnt + CNT_W'(1);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sha  <= '1;
      shb  <= '1;
      cmpa <= '1;
      cmpb <= '1;
    end else begin
      if (wr_a) sha <= wr_data;
      if (wr_b) shb <= wr_data;
      if (wr_a && !buf_en)     cmpa <= wr_data;
      else if (wrap && buf_en) cmpa <= sha;
      if (wr_b && !buf_en)     cmpb <= wr_data;
      else if (wrap && buf_en) cmpb <= shb;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      cmpa_pulse <= 1'b0;
      cmpb_pulse <= 1'b0;
      pwm_out    <= 1'b1;
    end else begin
      cmpa_pulse <= hit_a;
      cmpb_pulse <= wrap;
      if (clr || wrap) pwm_out <= 1'b1;
      else if (hit_a)  pwm_out <= 1'b0;
    end

  always_comb begin
    rd_data = '0;
    case (addr)
      A_CTL: begin
        rd_data[3:0]  = clk_sel;
        rd_data[B_RUN] = run;
        rd_data[B_ONE] = one_shot;
        rd_data[B_BUF] = buf_en;
        rd_data[B_BUSY] = busy;
      end
      A_CMPA:  rd_data = sha;
      A_CMPB:  rd_data = shb;
      A_CNT:   rd_data = cnt;
      default: rd_data = '0;
    endcase
  end

endmodule

module ptimer_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ctl_wr,
  input logic             clr,
  input logic             busy,
  input logic             wr_en,
  input logic [1:0]       addr,
  input logic [3:0]       clk_sel,
  input logic             run,
  input logic             one_shot,
  input logic             buf_en,
  input logic [CNT_W-1:0] cnt,
  input logic             cmpa_pulse,
  input logic             cmpb_pulse,
  input logic             pwm_out
);

  p_stop_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !ctl_wr) |=> $stable(cnt));

  p_wrap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cmpb_pulse |-> (cnt == '0 && pwm_out));

  p_cmpa_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cmpa_pulse && !cmpb_pulse && !$past(ctl_wr)) |-> !pwm_out);

  p_oneshot_stop_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cmpb_pulse && one_shot && !$past(ctl_wr)) |-> !run);

  p_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> cnt == '0);

  p_busy_set_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_wr |=> busy);

  p_busy_ignore_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && wr_en && addr == 2'd0) |=> ($stable(clk_sel) && $stable(one_shot) && $stable(buf_en)));

endmodule

bind ptimer ptimer_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .clr(clr), .busy(busy),
  .wr_en(wr_en), .addr(addr), .clk_sel(clk_sel), .run(run),
  .one_shot(one_shot), .buf_en(buf_en), .cnt(cnt),
  .cmpa_pulse(cmpa_pulse), .cmpb_pulse(cmpb_pulse), .pwm_out(pwm_out)
);

// File: tb/ptimer_bench.sv
`timescale 1ns/1ps
module ptimer_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ext_clk = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  addr = 2'd0;
  logic [15:0] wr_data = '0;
  logic [15:0] rd_data;
  logic        cmpa_pulse, cmpb_pulse, pwm_out;

  ptimer u_ptimer (
    .clk(clk), .rst_n(rst_n), .ext_clk(ext_clk), .wr_en(wr_en), .addr(addr),
    .wr_data(wr_data), .rd_data(rd_data), .cmpa_pulse(cmpa_pulse),
    .cmpb_pulse(cmpb_pulse), .pwm_out(pwm_out)
  );

  always #10 clk = ~clk;

  int n_chk = 0, n_fail = 0, cyc = 0, last_b = 0, eb = 0, ea = 0;
  bit done = 0, mon_on = 0, ext_on = 0;
  string cur_req = "R2";
  int qa[$];
  int qb[$];

  always @(posedge clk) cyc <= cyc + 1;

  initial forever begin
    repeat (6) @(negedge clk);
    if (ext_on) ext_clk = ~ext_clk;
  end

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic unexpected(input string req);
    n_chk++;
    n_fail++;
    $display("FAIL %s actual=pulse expected=none", req);
  endtask

  // Scoreboard monitor: pops expected pulse spacing as the design produces pulses
  always @(negedge clk) if (mon_on) begin
    if (cmpb_pulse) begin
      chk("R5 pwm high at wrap", pwm_out, 1);
      if (qb.size() == 0) unexpected({cur_req, " wrap"});
      else begin
        eb = qb.pop_front();
        if (eb >= 0) chk({cur_req, " wrap spacing"}, cyc - last_b, eb);
      end
      last_b = cyc;
    end
    if (cmpa_pulse) begin
      if (!cmpb_pulse) chk("R6 pwm low at compare A", pwm_out, 0);
      if (qa.size() == 0) unexpected({cur_req, " compare A"});
      else begin
        ea = qa.pop_front();
        if (ea >= 0) chk("R6 compare A after wrap", cyc - last_b, ea);
      end
    end
  end

  function automatic logic [15:0] cw(input int code, input bit run, input bit os,
                                     input bit bf, input bit clr);
    return {8'h00, clr, bf, os, run, 4'(code)};
  endfunction

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    addr = a; wr_data = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic ctl_w(input logic [15:0] d);
    wr(2'd0, d);
    repeat (3) @(negedge clk);
  endtask

  task automatic rd(input logic [1:0] a, output logic [15:0] v);
    addr = a;
    #1;
    v = rd_data;
  endtask

  task automatic drain();
    while (qa.size() != 0 || qb.size() != 0) @(negedge clk);
    mon_on = 0;
  endtask

  task automatic stop_clear();
    ctl_w(cw(0, 0, 0, 0, 1));
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=running expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    logic [15:0] v, v2;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(2'd0, v); chk("R1 control", v, 16'h0000);
    rd(2'd1, v); chk("R1 compare A", v, 16'hFFFF);
    rd(2'd2, v); chk("R1 compare B", v, 16'hFFFF);
    rd(2'd3, v); chk("R1 count", v, 0);
    chk("R1 pwm", pwm_out, 1);

    // R2 divide by 1, A=1 B=3
    wr(2'd1, 16'd1); wr(2'd2, 16'd3);
    cur_req = "R2 code0";
    qb = '{-1, 4, 4}; qa = '{-1, 2, 2};
    mon_on = 1;
    ctl_w(cw(0, 1, 0, 0, 0));
    drain();
    // R4 and R11: stop with junk in the upper bits
    ctl_w(16'hFF00);
    rd(2'd0, v); chk("R11 upper bits zero", v, 16'h0000);
    rd(2'd3, v);
    repeat (10) @(negedge clk);
    rd(2'd3, v2); chk("R4 count holds while stopped", v2, v);
    stop_clear();
    rd(2'd3, v); chk("R8 clear while stopped", v, 0);

    // R2 divide by 8
    cur_req = "R2 code3";
    qb = '{-1, 32, 32}; qa = '{-1, 16, 16};
    mon_on = 1;
    ctl_w(cw(3, 1, 0, 0, 0));
    drain();
    stop_clear();

    // R2 divide by 16384, A=0 B=1
    wr(2'd1, 16'd0); wr(2'd2, 16'd1);
    cur_req = "R2 code14";
    qb = '{-1, 32768}; qa = '{-1, 16384};
    mon_on = 1;
    ctl_w(cw(14, 1, 0, 0, 0));
    drain();
    stop_clear();

    // R3 external clock
    wr(2'd1, 16'd1); wr(2'd2, 16'd3);
    ctl_w(cw(15, 1, 0, 0, 0));
    repeat (30) @(negedge clk);
    rd(2'd3, v); chk("R3 static ext_clk no count", v, 0);
    cur_req = "R3 ext";
    qb = '{-1, 48, 48}; qa = '{-1, 24, 24};
    mon_on = 1;
    ext_on = 1;
    drain();
    ext_on = 0;
    stop_clear();

    // R9 buffered compare change takes effect at the wrap
    wr(2'd1, 16'd0); wr(2'd2, 16'd9);
    cur_req = "R9 buffered";
    qb = '{-1, 10, 10, 4, 4}; qa = '{-1, 1, 1, 1, 1, 1};
    mon_on = 1;
    ctl_w(cw(0, 1, 0, 1, 0));
    while (qb.size() > 3) @(negedge clk);
    wr(2'd2, 16'd3);
    rd(2'd2, v); chk("R9 shadow readback", v, 3);
    drain();
    stop_clear();

    // R9 unbuffered compare change takes effect at once
    wr(2'd2, 16'd9);
    cur_req = "R9 immediate";
    qb = '{-1, 4, 4}; qa = '{-1, 1, 1, 1};
    mon_on = 1;
    ctl_w(cw(0, 1, 0, 0, 0));
    while (qb.size() > 2) @(negedge clk);
    wr(2'd2, 16'd3);
    drain();
    stop_clear();

    // R7 one-shot
    wr(2'd1, 16'd1); wr(2'd2, 16'd3);
    cur_req = "R7 one-shot";
    qb = '{-1}; qa = '{-1};
    mon_on = 1;
    ctl_w(cw(0, 1, 1, 0, 0));
    while (qa.size() != 0 || qb.size() != 0) @(negedge clk);
    repeat (20) @(negedge clk);
    mon_on = 0;
    rd(2'd0, v); chk("R7 run bit cleared", v, 16'h0020);
    rd(2'd3, v); chk("R7 count stays 0", v, 0);
    stop_clear();

    // R10 busy window and ignored writes
    wr(2'd0, 16'h0005);
    rd(2'd0, v); chk("R10 busy cycle 1", v, 16'h0105);
    @(negedge clk);
    rd(2'd0, v); chk("R10 busy cycle 2", v, 16'h0105);
    @(negedge clk);
    rd(2'd0, v); chk("R10 idle after two cycles", v, 16'h0005);
    wr(2'd0, 16'h0006);
    wr(2'd0, 16'h000A);
    repeat (4) @(negedge clk);
    rd(2'd0, v); chk("R10 write while busy ignored", v, 16'h0006);

    // R8 clear while running
    wr(2'd1, 16'hFFFF); wr(2'd2, 16'hFFFF);
    ctl_w(cw(0, 1, 0, 0, 0));
    repeat (20) @(negedge clk);
    rd(2'd3, v); chk("R4 count advances while running", int'(v != 0), 1);
    wr(2'd0, cw(0, 1, 0, 0, 1));
    rd(2'd3, v); chk("R8 clear while running", v, 0);
    repeat (4) @(negedge clk);
    rd(2'd0, v); chk("R8 clear bit reads 0", v, 16'h0010);

    done = 1;
    summary();
    $finish;
  end

endmodule